// File: doc/BRIEF.md
# Head-per-track disk controller command decoder

This block sits between the processor's I/O instruction bus and the transfer engine of a head-per-track disk controller. It holds the controller's programmer-visible state: an 18-bit status/function word, a 21-bit disk word address and an 18-bit data buffer. It turns each I/O instruction into register loads, readbacks, a skip request and a start strobe for the engine. Moving data and modelling disk rotation are left to the engine. The engine reports back through a busy level and a completion strobe.

An instruction selects one of two command groups, each with its own select strobe: the main group or the status group. It carries a six-bit pulse field. Bits 5:4 are a sub-opcode shared by all phases of the instruction. Bits 0, 1 and 2 enable three phases, which are evaluated in that order within the single select cycle, so a later phase sees what an earlier phase did. The readback bus is combinational in the select cycle and is the incoming data bus ORed with any value read. The skip and start outputs are also combinational in that cycle. Register updates land on the following clock edge.

Top module: `hpt_disk_cmd`

## Requirements
- R1: A synchronous active-high reset clears the status word, disk address and data buffer, which leaves `func` at 0 and `irq` low.
- R2: In the main group, phase 0 with sub-opcode 00 raises `skip` in that cycle when status bit 17 (error) or bit 7 (done) is set.
- R3: In the main group, phase 0 with sub-opcode 01 resets the whole controller as in R1. Phases 1 and 2 of the same instruction see the cleared state and are not blocked by `busy`.
- R4: While `busy` is high, the following are refused and set status bit 8 (programming error) instead: main phase 0 sub-opcode 10, every main phase 1 and phase 2 command, and status-group phase 1 sub-opcodes 10 and 11. The status read still returns its value.
- R5: Every status update forces bits 6:3 to zero. It sets bit 17 exactly when any of bits 16:10 is set. Bit 10 is the non-existent-disk flag.
- R6: `irq` is high exactly when status bit 0 (interrupt enable) is set and bit 17 or bit 7 is set.
- R7: Main phase 1 with sub-opcode 10 XORs `din[2:0]` into status bits 2:0. Bits 2:1 are the function, seen on `func`, and bit 0 is the interrupt enable. Main phase 0 with sub-opcode 10 clears bits 2:0.
- R8: Main phase 1 reads are ORed onto `din`: sub-opcode 00 returns the data buffer, 01 returns address bits 17:0, and 11 returns address bits 20:18 in bits 2:0 with the non-existent-disk flag in bit 3. Status-group phase 1 with sub-opcode 11 returns the updated status word.
- R9: Main phase 2 with sub-opcode 10 clears done. It raises `start` in that cycle only when the function is non-zero.
- R10: Main phase 2 with sub-opcode 11 sets the non-existent-disk flag when `din[2:0]` is at least `PLATTERS`. The flag is sticky until a status clear or a reset.
- R11: Status-group phase 1 with sub-opcode 10 keeps only status bits 2:0 and clears the rest.
- R12: Main phase 2 loads registers: sub-opcode 00 loads the data buffer from `din`; 01 loads address bits 17:0 and keeps bits 20:18; 11 loads address bits 20:18 from `din[2:0]` and keeps bits 17:0.
- R13: A `xfer_done` strobe sets status bit 7 (done).
- R14: Within one instruction, phases run in the order 0, 1, 2 on the same sub-opcode. For example, pulse field 100111 clears the function, XORs in a new one and then starts on that new value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| main_sel | input | 1 | Strobe selecting the main command group for this cycle |
| stat_sel | input | 1 | Strobe selecting the status command group for this cycle |
| pulse | input | 6 | Bits 5:4 sub-opcode, bits 2:0 phase enables |
| din | input | 18 | Data from the I/O bus |
| busy | input | 1 | Transfer engine is running |
| xfer_done | input | 1 | Transfer engine finished a transfer |
| dout | output | 18 | `din` ORed with any readback value |
| skip | output | 1 | Skip request for the current instruction |
| irq | output | 1 | Interrupt request |
| start | output | 1 | One-cycle request for the engine to begin a transfer |
| func | output | 2 | Current function code |

## Verification
The bench targets three kinds of corner case. The first is the phase ordering inside one instruction. A decoder that evaluated all phases against the old state would start on a stale function when given pulse 100111, and would block the read that follows an in-instruction reset. The second is busy refusal. A design that let one refused command slip through would change the buffer or function under a running transfer and leave bit 8 clear. The third is the status normalisation and the address limit. A compare off by one at `PLATTERS`, or a summary bit not recomputed after a status clear, shows up as a wrong status readback or a stuck `irq`. A sweep of all 64 pulse codes over both groups, with `busy` high and low, checks every output against an arithmetic model.

// File: rtl/hpt_disk_pkg.sv
package hpt_disk_pkg;

    localparam int DATA_W = 18;
    localparam int ADDR_W = 21;
    localparam int LOW_W  = 18;
    localparam int HIGH_W = ADDR_W - LOW_W;
    localparam int NED_IDX = 0;   // position of the non-existent-disk flag in eflg

    // Status word, MSB first: bit 17 down to bit 0
    typedef struct packed {
        logic       err;    // 17 summary
        logic [6:0] eflg;   // 16..10 individual error flags, eflg[0] = non-existent disk
        logic       dch;    // 9
        logic       pge;    // 8 programming error
        logic       done;   // 7
        logic [3:0] rsvd;   // 6..3 always zero after an update
        logic [1:0] fn;     // 2..1 function
        logic       ie;     // 0 interrupt enable
    } sta_t;

    typedef struct packed {
        logic chk_skip;
        logic do_reset;
        logic clr_fn;
        logic ph2;
        logic rd_buf;
        logic rd_alo;
        logic xor_fn;
        logic rd_ahi;
        logic ph3;
        logic ld_buf;
        logic ld_alo;
        logic go;
        logic ld_ahi;
        logic clr_sta;
        logic rd_sta;
    } ops_t;

    function automatic sta_t sta_norm(sta_t s);
        sta_t r;
        r      = s;
        r.rsvd = '0;
        r.err  = |s.eflg;
        return r;
    endfunction

    function automatic sta_t sta_keep_fr(sta_t s);
        sta_t r;
        r    = '0;
        r.fn = s.fn;
        r.ie = s.ie;
        return r;
    endfunction

endpackage

// File: rtl/hpt_disk_decode.sv
module hpt_disk_decode
    import hpt_disk_pkg::*;
(
    input  logic       main_sel,
    input  logic       stat_sel,
    input  logic [5:0] pulse,
    output ops_t       ops
);

    logic [1:0] sb;
    assign sb = pulse[5:4];

    always_comb begin
        ops = '0;
        if (main_sel) begin
            ops.chk_skip = pulse[0] && (sb == 2'b00);
            ops.do_reset = pulse[0] && (sb == 2'b01);
            ops.clr_fn   = pulse[0] && (sb == 2'b10);
            ops.ph2      = pulse[1];
            ops.rd_buf   = pulse[1] && (sb == 2'b00);
            ops.rd_alo   = pulse[1] && (sb == 2'b01);
            ops.xor_fn   = pulse[1] && (sb == 2'b10);
            ops.rd_ahi   = pulse[1] && (sb == 2'b11);
            ops.ph3      = pulse[2];
            ops.ld_buf   = pulse[2] && (sb == 2'b00);
            ops.ld_alo   = pulse[2] && (sb == 2'b01);
            ops.go       = pulse[2] && (sb == 2'b10);
            ops.ld_ahi   = pulse[2] && (sb == 2'b11);
        end
        if (stat_sel) begin
            ops.clr_sta = pulse[1] && (sb == 2'b10);
            ops.rd_sta  = pulse[1] && (sb == 2'b11);
        end
    end

endmodule

// File: rtl/hpt_disk_exec.sv
module hpt_disk_exec
    import hpt_disk_pkg::*;
#(
    parameter int PLATTERS = 4
) (
    input  sta_t                cur_sta,
    input  logic [ADDR_W-1:0]   cur_da,
    input  logic [DATA_W-1:0]   cur_buf,
    input  logic                busy,
    input  logic                xfer_done,
    input  logic [DATA_W-1:0]   din,
    input  ops_t                ops,
    output sta_t                nxt_sta,
    output logic [ADDR_W-1:0]   nxt_da,
    output logic [DATA_W-1:0]   nxt_buf,
    output logic [DATA_W-1:0]   dout,
    output logic                skip,
    output logic                start
);

    localparam logic [HIGH_W:0] CAP = (HIGH_W+1)'(PLATTERS);

    logic blk;
    sta_t snorm;

    always_comb begin
        nxt_sta = cur_sta;
        nxt_da  = cur_da;
        nxt_buf = cur_buf;
        dout    = din;
        skip    = 1'b0;
        start   = 1'b0;
        blk     = busy;
        snorm   = '0;

        if (xfer_done) nxt_sta.done = 1'b1;

        // phase 0
        if (ops.chk_skip && (nxt_sta.err || nxt_sta.done)) skip = 1'b1;
        if (ops.do_reset) begin
            nxt_sta = '0;
            nxt_da  = '0;
            nxt_buf = '0;
            blk     = 1'b0;
        end
        if (ops.clr_fn) begin
            if (blk) nxt_sta.pge = 1'b1;
            else begin
                nxt_sta.fn = 2'b00;
                nxt_sta.ie = 1'b0;
            end
        end

        // phase 1
        if (ops.ph2) begin
            if (blk) nxt_sta.pge = 1'b1;
            else begin
                if (ops.rd_buf) dout = dout | nxt_buf;
                if (ops.rd_alo) dout = dout | nxt_da[LOW_W-1:0];
                if (ops.xor_fn) {nxt_sta.fn, nxt_sta.ie} = {nxt_sta.fn, nxt_sta.ie} ^ din[2:0];
                if (ops.rd_ahi)
                    dout = dout | {{(DATA_W-HIGH_W-1){1'b0}}, nxt_sta.eflg[NED_IDX], nxt_da[ADDR_W-1:LOW_W]};
            end
        end

        // phase 2
        if (ops.ph3) begin
            if (blk) nxt_sta.pge = 1'b1;
            else begin
                if (ops.ld_buf) nxt_buf = din;
                if (ops.ld_alo) nxt_da[LOW_W-1:0] = din;
                if (ops.go) begin
                    nxt_sta.done = 1'b0;
                    start = (nxt_sta.fn != 2'b00);
                end
                if (ops.ld_ahi) begin
                    nxt_da[ADDR_W-1:LOW_W] = din[HIGH_W-1:0];
                    if ({1'b0, din[HIGH_W-1:0]} >= CAP) nxt_sta.eflg[NED_IDX] = 1'b1;
                end
            end
        end

        // status group
        if (ops.clr_sta) begin
            if (blk) nxt_sta.pge = 1'b1;
            else nxt_sta = sta_keep_fr(nxt_sta);
        end
        if (ops.rd_sta) begin
            if (blk) nxt_sta.pge = 1'b1;
            snorm = sta_norm(nxt_sta);
            dout  = dout | snorm;
        end

        nxt_sta = sta_norm(nxt_sta);
    end

endmodule

// File: rtl/hpt_disk_cmd.sv
module hpt_disk_cmd
    import hpt_disk_pkg::*;
#(
    parameter int PLATTERS = 4
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        main_sel,
    input  logic        stat_sel,
    input  logic [5:0]  pulse,
    input  logic [17:0] din,
    input  logic        busy,
    input  logic        xfer_done,
    output logic [17:0] dout,
    output logic        skip,
    output logic        irq,
    output logic        start,
    output logic [1:0]  func
);

    sta_t               sta_q, sta_d;
    logic [ADDR_W-1:0]  da_q,  da_d;
    logic [DATA_W-1:0]  buf_q, buf_d;
    ops_t               ops;

    hpt_disk_decode i_dec (
        .main_sel (main_sel),
        .stat_sel (stat_sel),
        .pulse    (pulse),
        .ops      (ops)
    );

    hpt_disk_exec #(.PLATTERS(PLATTERS)) i_exec (
        .cur_sta   (sta_q),
        .cur_da    (da_q),
        .cur_buf   (buf_q),
        .busy      (busy),
        .xfer_done (xfer_done),
        .din       (din),
        .ops       (ops),
        .nxt_sta   (sta_d),
        .nxt_da    (da_d),
        .nxt_buf   (buf_d),
        .dout      (dout),
        .skip      (skip),
        .start     (start)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            sta_q <= '0;
            da_q  <= '0;
            buf_q <= '0;
        end else begin
            sta_q <= sta_d;
            da_q  <= da_d;
            buf_q <= buf_d;
        end
    end

    assign func = sta_q.fn;
    assign irq  = sta_q.ie & (sta_q.err | sta_q.done);

endmodule

// File: rtl/hpt_disk_cmd_chk.sv
module hpt_disk_cmd_chk #(
    parameter int PLATTERS = 4
) (
    input logic        clk,
    input logic        rst,
    input logic        main_sel,
    input logic        stat_sel,
    input logic [5:0]  pulse,
    input logic [17:0] din,
    input logic        busy,
    input logic        start,
    input logic        irq,
    input logic [1:0]  func,
    input logic [17:0] sta_q,
    input logic [20:0] da_q,
    input logic [17:0] buf_q
);

    localparam logic [3:0] CAP = 4'(PLATTERS);

    // R1
    p_reset_clears_r1: assert property (@(posedge clk)
        rst |=> (sta_q == 18'd0 && da_q == 21'd0 && buf_q == 18'd0 && !irq && func == 2'd0));

    // R5
    p_status_shape_r5: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (sta_q[6:3] == 4'd0 && sta_q[17] == (|sta_q[16:10])));

    // R9
    p_start_gated_r9: assert property (@(posedge clk) disable iff (rst)
        start |-> (!busy && main_sel && pulse[2] && pulse[5:4] == 2'b10));

    // R9
    p_start_func_r9: assert property (@(posedge clk) disable iff (rst)
        start |=> (func != 2'd0 && !sta_q[7]));

    // R4
    p_busy_refusal_r4: assert property (@(posedge clk) disable iff (rst)
        (main_sel && busy && pulse[1] && !(pulse[0] && pulse[5:4] == 2'b01)) |=> sta_q[8]);

    // R10
    p_ned_limit_r10: assert property (@(posedge clk) disable iff (rst)
        (main_sel && !stat_sel && !busy && pulse[2] && pulse[5:4] == 2'b11 && {1'b0, din[2:0]} >= CAP)
        |=> (sta_q[10] && sta_q[17]));

    // R12
    p_idle_hold_r12: assert property (@(posedge clk) disable iff (rst)
        (!main_sel && !stat_sel) |=> ($stable(da_q) && $stable(buf_q)));

endmodule

bind hpt_disk_cmd hpt_disk_cmd_chk #(.PLATTERS(PLATTERS)) i_chk (
    .clk      (clk),
    .rst      (rst),
    .main_sel (main_sel),
    .stat_sel (stat_sel),
    .pulse    (pulse),
    .din      (din),
    .busy     (busy),
    .start    (start),
    .irq      (irq),
    .func     (func),
    .sta_q    (sta_q),
    .da_q     (da_q),
    .buf_q    (buf_q)
);

// File: tb/test_hpt_disk_cmd.sv
`timescale 1ns/1ps
module test_hpt_disk_cmd;

    localparam int PLAT = 4;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        main_sel = 1'b0;
    logic        stat_sel = 1'b0;
    logic [5:0]  pulse = '0;
    logic [17:0] din = '0;
    logic        busy = 1'b0;
    logic        xfer_done = 1'b0;
    logic [17:0] dout;
    logic        skip, irq, start;
    logic [1:0]  func;

    int n_tests = 0;
    int n_fail  = 0;
    int m_sta = 0, m_da = 0, m_buf = 0;
    int o_dout, o_skip, o_start;

    always #2 clk = ~clk;

    hpt_disk_cmd #(.PLATTERS(PLAT)) i_hpt_disk_cmd (
        .clk(clk), .rst(rst), .main_sel(main_sel), .stat_sel(stat_sel),
        .pulse(pulse), .din(din), .busy(busy), .xfer_done(xfer_done),
        .dout(dout), .skip(skip), .irq(irq), .start(start), .func(func)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s act=%0h exp=%0h", req, act, exp);
        end
    endtask

    function automatic int norm(input int s);
        int r = s & ~('h20000 | 'h78);
        if ((r & 'h1fc00) != 0) r = r | 'h20000;
        return r;
    endfunction

    // arithmetic model from the requirements; g: 0 main, 1 status, 2 none
    task automatic model(input int g, input int p, input int d, input int bzi, input int dn,
                         output int q, output int sk, output int st);
        int s = m_sta, a = m_da, b = m_buf, bz = bzi;
        int sb = (p >> 4) & 3;
        q = d; sk = 0; st = 0;
        if (dn != 0) s = s | 'h80;
        if (g == 0) begin
            if ((p & 1) != 0) begin
                if (sb == 0 && ((((s >> 17) & 1) != 0) || (((s >> 7) & 1) != 0))) sk = 1;
                if (sb == 1) begin s = 0; a = 0; b = 0; bz = 0; end
                if (sb == 2) begin if (bz != 0) s = s | 'h100; else s = s & ~7; end
            end
            if ((p & 2) != 0) begin
                if (bz != 0) s = s | 'h100;
                else case (sb)
                    0: q = q | b;
                    1: q = q | (a & 'h3ffff);
                    2: s = s ^ (d & 7);
                    default: q = q | ((a >> 18) & 7) | ((((s >> 10) & 1) != 0) ? 8 : 0);
                endcase
            end
            if ((p & 4) != 0) begin
                if (bz != 0) s = s | 'h100;
                else case (sb)
                    0: b = d;
                    1: a = (a & ~'h3ffff) | d;
                    2: begin s = s & ~'h80; if (((s >> 1) & 3) != 0) st = 1; end
                    default: begin
                        a = (a & 'h3ffff) | ((d & 7) << 18);
                        if ((d & 7) >= PLAT) s = s | 'h400;
                    end
                endcase
            end
        end else if (g == 1 && (p & 2) != 0) begin
            if (sb == 2) begin if (bz != 0) s = s | 'h100; else s = s & 7; end
            if (sb == 3) begin if (bz != 0) s = s | 'h100; q = q | norm(s); end
        end
        m_sta = norm(s); m_da = a; m_buf = b;
    endtask

    task automatic do_cmd(input int g, input int p, input int d, input int bz, input int dn);
        int eq, esk, est, ef, ei;
        model(g, p, d & 'h3ffff, bz, dn, eq, esk, est);
        ef = (m_sta >> 1) & 3;
        ei = ((m_sta & 1) != 0 && (m_sta & 'h20080) != 0) ? 1 : 0;
        main_sel  = (g == 0);
        stat_sel  = (g == 1);
        pulse     = p[5:0];
        din       = d[17:0];
        busy      = bz[0];
        xfer_done = dn[0];
        #1;
        o_dout = int'(dout); o_skip = int'(skip); o_start = int'(start);
        chk(o_dout == eq,   "R8 readback", o_dout, eq);
        chk(o_skip == esk,  "R2 skip", o_skip, esk);
        chk(o_start == est, "R9 start", o_start, est);
        @(posedge clk);
        #1;
        main_sel = 1'b0; stat_sel = 1'b0; busy = 1'b0; xfer_done = 1'b0; pulse = '0; din = '0;
        chk(int'(func) == ef, "R7 func", int'(func), ef);
        chk(int'(irq) == ei,  "R6 irq", int'(irq), ei);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
        // R1 reset state
        chk(func == 2'd0, "R1 func after reset", int'(func), 0);
        chk(irq == 1'b0,  "R1 irq after reset", int'(irq), 0);
        do_cmd(1, 'h32, 0, 0, 0);
        chk(o_dout == 0, "R1 status zero", o_dout, 0);

        // R12 / R8 data buffer
        do_cmd(0, 'h04, 'h2A5A5, 0, 0);
        do_cmd(0, 'h02, 'h00002, 0, 0);
        chk(o_dout == 'h2A5A7, "R12 buffer load, R8 ORed read", o_dout, 'h2A5A7);
        // R12 address halves
        do_cmd(0, 'h14, 'h12345, 0, 0);
        do_cmd(0, 'h34, 2, 0, 0);
        do_cmd(0, 'h12, 0, 0, 0);
        chk(o_dout == 'h12345, "R12 low address", o_dout, 'h12345);
        do_cmd(0, 'h14, 1, 0, 0);
        do_cmd(0, 'h32, 0, 0, 0);
        chk(o_dout == 2, "R12 high kept on low load", o_dout, 2);

        // R7 xor load
        do_cmd(0, 'h22, 3, 0, 0);
        chk(func == 2'd1, "R7 xor 011", int'(func), 1);
        do_cmd(0, 'h22, 1, 0, 0);
        do_cmd(0, 'h22, 6, 0, 0);
        chk(func == 2'd2, "R7 xor 110 onto 010", int'(func), 2);
        // R9 start
        do_cmd(0, 'h24, 0, 0, 0);
        chk(o_start == 1, "R9 start with function", o_start, 1);
        do_cmd(0, 'h21, 0, 0, 0);
        chk(func == 2'd0, "R7 clear function", int'(func), 0);
        do_cmd(0, 'h24, 0, 0, 0);
        chk(o_start == 0, "R9 no start on no-op", o_start, 0);

        // R13 done, R2 skip, R6 irq
        do_cmd(0, 'h22, 1, 0, 0);
        do_cmd(2, 0, 0, 0, 1);
        chk(irq == 1'b1, "R13 done sets irq", int'(irq), 1);
        do_cmd(0, 'h01, 0, 0, 0);
        chk(o_skip == 1, "R2 skip on done", o_skip, 1);
        do_cmd(0, 'h24, 0, 0, 0);
        chk(irq == 1'b0, "R9 start clears done", int'(irq), 0);

        // R4 busy refusal
        do_cmd(0, 'h04, 'h11111, 1, 0);
        do_cmd(0, 'h02, 0, 0, 0);
        chk(o_dout == 'h2A5A5, "R4 busy load refused", o_dout, 'h2A5A5);
        do_cmd(1, 'h32, 0, 0, 0);
        chk((o_dout & 'h100) != 0, "R4 programming error flag", o_dout, 'h101);
        do_cmd(0, 'h21, 0, 1, 0);
        chk(func == 2'd0 && (m_sta & 1) == 1, "R4 busy clear-function refused", int'(func), 0);

        // R11 clear status
        do_cmd(1, 'h22, 0, 0, 0);
        do_cmd(1, 'h32, 0, 0, 0);
        chk(o_dout == 1, "R11 clear keeps function bits", o_dout, 1);

        // R10 / R5 high address limit
        do_cmd(0, 'h34, 5, 0, 0);
        do_cmd(1, 'h32, 0, 0, 0);
        chk(o_dout == 'h20401, "R10 R5 status after bad disk", o_dout, 'h20401);
        chk(irq == 1'b1, "R6 error interrupt", int'(irq), 1);
        do_cmd(0, 'h32, 0, 0, 0);
        chk(o_dout == 'hD, "R8 high address with flag", o_dout, 'hD);

        // R3 reset inside instruction, not blocked by busy
        do_cmd(0, 'h13, 'h00040, 1, 0);
        chk(o_dout == 'h40, "R3 read after in-instruction reset", o_dout, 'h40);
        do_cmd(1, 'h32, 0, 0, 0);
        chk(o_dout == 0, "R3 no programming error", o_dout, 0);

        // R10 boundary
        do_cmd(0, 'h34, PLAT - 1, 0, 0);
        do_cmd(1, 'h32, 0, 0, 0);
        chk(o_dout == 0, "R10 below limit", o_dout, 0);
        do_cmd(0, 'h34, PLAT, 0, 0);
        do_cmd(1, 'h32, 0, 0, 0);
        chk((o_dout & 'h20400) == 'h20400, "R10 at limit", o_dout, 'h20400);

        // R14 phase order
        do_cmd(0, 'h11, 0, 0, 0);
        do_cmd(0, 'h27, 3, 0, 0);
        chk(o_start == 1 && func == 2'd1, "R14 clear-xor-start order", o_start, 1);
        do_cmd(0, 'h27, 3, 0, 0);
        chk(o_start == 1, "R14 repeated sequence", o_start, 1);

        // sweep of all pulse codes, both groups, busy high and low
        for (int p = 0; p < 64; p++)
            for (int g = 0; g < 2; g++)
                for (int bz = 0; bz < 2; bz++)
                    do_cmd(g, p, (p * 1237 + g * 77 + bz * 5 + 3) & 'h3ffff, bz, (p % 7 == 3) ? 1 : 0);

        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        #600000;
        n_tests++;
        n_fail++;
        $display("FAIL watchdog expired");
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule